// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor

This block sits on the 4-bit parallel receive path behind a clock-recovery front end. It looks for bit transitions in the incoming stream. The stream may go quiet for longer than a set time, or the optical module's signal-detect pin may disagree with the configured polarity. In either case the block raises a loss-of-signal alarm. The alarm is sticky: it stays up, whatever the data does, until the receiver sees the two-byte framing sequence 0xF6 followed by 0x28.

While the alarm is up, the data passed downstream is replaced by zeroes, and a clock-select output tells the clocking logic to run from the local reference rather than the recovered clock. Received words still flow through the monitor's own detectors during the alarm, so the framing search goes on. The quiet timeout is given in nanoseconds together with the clock frequency in MHz. At 625 MHz, 2300 ns becomes 1438 cycles.

Top module: `los_monitor`

## Requirements
- R1: After reset, `los_alarm` and `refclk_sel` are 0 and `out_data` equals `rx_data`.
- R2: After `QUIET_CYC` consecutive words without a transition, `los_alarm` is 1 following the next clock edge. `QUIET_CYC` = ceil(`CLK_MHZ` × `QUIET_NS` / 1000). If a transition comes in word `QUIET_CYC`-1 or earlier, there is no alarm.
- R3: `rx_data[3]` is the earliest bit and `rx_data[0]` the latest. A word counts as a transition if two adjacent bits inside it differ, or if its bit 3 differs from bit 0 of the previous word. The first word after reset has no previous word.
- R4: Once set, `los_alarm` stays 1 however the data toggles, until the framing sequence is seen.
- R5: The alarm clears on the edge that takes in the fourth of four consecutive words 0xF, 0x6, 0x2, 0x8, which form bytes 0xF6 and 0x28. The sequence may begin on any word, so either byte alignment works.
- R6: A set condition (quiet timeout or detect mismatch) in the same cycle as the end of the framing sequence keeps the alarm set.
- R7: `sig_det` != `pol_sel` sets `los_alarm` on the next edge, whichever level `pol_sel` has. `pol_sel` gives the level `sig_det` shows while optical signal is present.
- R8: `out_data` is 0 while `los_alarm` is 1 and otherwise equals `rx_data` in the same cycle.
- R9: `refclk_sel` equals `los_alarm` at all times.
- R10: A partial or broken sequence, such as 0xF, 0x6, 0x2, 0x9, does not clear the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 4 | Received word, bit 3 earliest |
| sig_det | input | 1 | Signal-detect pin from the optics |
| pol_sel | input | 1 | Level of `sig_det` that means signal present |
| out_data | output | 4 | Forwarded word, zeroed during alarm |
| los_alarm | output | 1 | Sticky loss-of-signal alarm |
| refclk_sel | output | 1 | Run receive clocking from the reference |

## Verification
Some behaviour is checked on every cycle by assertions. A quiet timeout or a detect mismatch is always followed by a set alarm. A set alarm holds unless the framing sequence arrives, and it drops when that sequence arrives with no set condition present. Any observed transition also clears the timeout. The exact cycle count to the alarm, the transition rule at word boundaries, and the rejection of near-miss sequences can only be shown by the bench. It sweeps all sixteen held word values, alternating boundary-only patterns, all four detect/polarity combinations and broken framing sequences against an arithmetic model.

// File: rtl/los_pkg.sv
package los_pkg;
    localparam int WORD_W     = 4;
    localparam int FRAME_BITS = 16;
    localparam logic [FRAME_BITS-1:0] FRAME_SEQ = 16'hF628;

    typedef struct packed {
        logic quiet;   // no transition for the full timeout
        logic ext;     // detect pin disagrees with polarity
        logic frame;   // framing sequence completed this word
    } los_events_t;

    function automatic logic word_toggles(input logic [WORD_W-1:0] w);
        return |(w[WORD_W-1:1] ^ w[WORD_W-2:0]);
    endfunction

    function automatic int cycles_for(input int mhz, input int ns);
        return (mhz * ns + 999) / 1000;
    endfunction
endpackage

// File: rtl/los_activity.sv
module los_activity #(
    parameter int QUIET_CYC = 1438
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [los_pkg::WORD_W-1:0] word,
    output logic                      quiet
);
    localparam int CW = $clog2(QUIET_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYC);

    logic          have_prev;
    logic          prev_last;
    logic [CW-1:0] quiet_cnt;
    logic          edge_seen;

    always_comb begin
        edge_seen = los_pkg::word_toggles(word)
                  || (have_prev && (prev_last != word[los_pkg::WORD_W-1]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_last <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            have_prev <= 1'b1;
            prev_last <= word[0];
            if (edge_seen)
                quiet_cnt <= '0;
            else if (quiet_cnt != LIMIT)
                quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign quiet = (quiet_cnt == LIMIT);

    AST_EDGE_CLEARS_QUIET: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> !quiet); // R3
endmodule

// File: rtl/los_framer.sv
module los_framer (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [los_pkg::WORD_W-1:0] word,
    output logic                      hit
);
    localparam int HIST = los_pkg::FRAME_BITS - los_pkg::WORD_W;

    logic [HIST-1:0]               hist;
    logic [los_pkg::FRAME_BITS-1:0] window;

    assign window = {hist, word};
    assign hit    = (window == los_pkg::FRAME_SEQ);

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= window[HIST-1:0];
    end
endmodule

// File: rtl/los_latch.sv
module los_latch (
    input  logic                 clk,
    input  logic                 rst,
    input  los_pkg::los_events_t ev,
    output logic                 alarm
);
    always_ff @(posedge clk) begin
        if (rst)
            alarm <= 1'b0;
        else if (ev.quiet || ev.ext)
            alarm <= 1'b1;
        else if (ev.frame)
            alarm <= 1'b0;
    end

    AST_QUIET_SETS: assert property (@(posedge clk) disable iff (rst)
        ev.quiet |=> alarm); // R2
    AST_EXT_SETS: assert property (@(posedge clk) disable iff (rst)
        ev.ext |=> alarm); // R7
    AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (alarm && !ev.frame) |=> alarm); // R4
    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (alarm && ev.frame && !ev.quiet && !ev.ext) |=> !alarm); // R5
endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
    parameter int CLK_MHZ   = 625,
    parameter int QUIET_NS  = 2300,
    parameter int QUIET_CYC = los_pkg::cycles_for(CLK_MHZ, QUIET_NS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rx_data,
    input  logic       sig_det,
    input  logic       pol_sel,
    output logic [3:0] out_data,
    output logic       los_alarm,
    output logic       refclk_sel
);
    los_pkg::los_events_t ev;
    logic quiet, hit, alarm;

    los_activity #(.QUIET_CYC(QUIET_CYC)) u_activity (
        .clk(clk), .rst(rst), .word(rx_data), .quiet(quiet));

    los_framer u_framer (
        .clk(clk), .rst(rst), .word(rx_data), .hit(hit));

    always_comb begin
        ev.quiet = quiet;
        ev.ext   = sig_det ^ pol_sel;
        ev.frame = hit;
    end

    los_latch u_latch (
        .clk(clk), .rst(rst), .ev(ev), .alarm(alarm));

    assign los_alarm  = alarm;
    assign refclk_sel = alarm;
    assign out_data   = alarm ? '0 : rx_data;
endmodule

// File: tb/los_monitor_tb_top.sv
module los_monitor_tb_top;
    localparam int PERIOD = 10;
    localparam int T      = 10;   // 10 MHz x 1000 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rx_data = 4'h0;
    logic       sig_det = 1'b0;
    logic       pol_sel = 1'b0;
    logic [3:0] out_data;
    logic       los_alarm, refclk_sel;

    int vectors = 0;
    int errors  = 0;

    int         m_cnt;
    bit         m_have, m_last, m_alarm;
    logic [11:0] m_hist;

    always #(PERIOD/2) clk = ~clk;

    los_monitor #(.CLK_MHZ(10), .QUIET_NS(1000)) dut_i (
        .clk(clk), .rst(rst), .rx_data(rx_data), .sig_det(sig_det),
        .pol_sel(pol_sel), .out_data(out_data), .los_alarm(los_alarm),
        .refclk_sel(refclk_sel));

    task automatic check_bit(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one word: drive, check combinational output, clock, check registered state
    task automatic tick(input logic [3:0] d, input string tag);
        bit trans, quiet, ext, hit;
        rx_data = d;
        #1;
        check_word("R8", out_data, m_alarm ? 4'h0 : d);
        trans = (|(d[3:1] ^ d[2:0])) || (m_have && (m_last != d[3]));
        quiet = (m_cnt == T);
        ext   = sig_det ^ pol_sel;
        hit   = ({m_hist, d} == 16'hF628);
        if (quiet || ext) m_alarm = 1'b1;
        else if (hit)     m_alarm = 1'b0;
        m_cnt  = trans ? 0 : ((m_cnt == T) ? T : m_cnt + 1);
        m_have = 1'b1;
        m_last = d[0];
        m_hist = {m_hist[7:0], d};
        @(posedge clk); #1;
        check_bit(tag, los_alarm, m_alarm);
        check_bit("R9", refclk_sel, m_alarm);
    endtask

    task automatic send_frame(input string tag);
        tick(4'hF, tag); tick(4'h6, tag); tick(4'h2, tag); tick(4'h8, tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_cnt = 0; m_have = 0; m_last = 0; m_alarm = 0; m_hist = '0;
        rx_data = 4'h5;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check_bit("R1", los_alarm, 1'b0);
        check_bit("R1", refclk_sel, 1'b0);
        check_word("R1", out_data, 4'h5);

        // R2/R3: every held word value, then frame to recover
        for (int v = 0; v < 16; v++) begin
            tick(4'h5, "R3");
            for (int k = 0; k < T + 3; k++)
                tick(4'(v), (v == 0 || v == 15) ? "R2" : "R3");
            send_frame("R5");
            tick(4'hA, "R5");
        end

        // R3: boundary-only transitions between 0 and F words
        for (int k = 0; k < 3 * T; k++) tick((k % 2) ? 4'hF : 4'h0, "R3");

        // R2: T-1 quiet words then a transition, repeated
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < T - 1; k++) tick(4'h0, "R2");
            tick(4'h3, "R2");
            tick(4'hC, "R2");
        end

        // raise alarm, then R4 hold under toggling data
        for (int k = 0; k < T + 1; k++) tick(4'hF, "R2");
        for (int k = 0; k < 20; k++) tick(4'h5, "R4");
        // R10 broken sequences
        tick(4'hF, "R10"); tick(4'h6, "R10"); tick(4'h2, "R10"); tick(4'h9, "R10");
        tick(4'hF, "R10"); tick(4'h6, "R10"); tick(4'h5, "R10"); tick(4'h8, "R10");
        tick(4'hF, "R10"); tick(4'h2, "R10"); tick(4'h8, "R10");
        // R5 odd alignment then clear
        tick(4'h3, "R5");
        send_frame("R5");
        for (int k = 0; k < 4; k++) tick(4'h9, "R5");

        // R7: all detect/polarity combinations
        for (int c = 0; c < 4; c++) begin
            pol_sel = c[1];
            sig_det = c[0];
            tick(4'h6, "R7");
            tick(4'h9, "R7");
            // R6: frame while mismatch persists keeps alarm
            send_frame("R6");
            sig_det = pol_sel;
            tick(4'h5, "R7");
            send_frame("R5");
            tick(4'hA, "R5");
        end

        // R6: quiet timeout coincident with frame end is impossible in data,
        // so exercise mismatch arriving exactly on the final frame word
        tick(4'h0, "R6");
        for (int k = 0; k < T; k++) tick(4'h0, "R2");
        tick(4'hF, "R6"); tick(4'h6, "R6"); tick(4'h2, "R6");
        sig_det = ~pol_sel;
        tick(4'h8, "R6");
        sig_det = pol_sel;
        tick(4'h5, "R6");
        send_frame("R5");
        tick(4'hA, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule